// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers eight shared PCI interrupt request lines, called PIRQ A to PIRQ H here, onto a bank of 24 interrupt controller inputs. Lines 0 to 15 feed a legacy programmable interrupt controller (PIC). Lines 16 to 23 feed an I/O APIC. Each PIRQ owns one APIC-side line and cannot share it.

On the PIC side, each PIRQ has a routing byte. The byte picks one of sixteen lines, or disables the PIRQ on that side. Any number of enabled PIRQs may land on the same PIC line, and that line then carries the OR of their levels. A power-management SCI request is ORed onto one further line, which a select code in a control byte chooses. Moving the selection while the SCI is high moves the asserted level from the old line to the new one.

The block also holds a per-slot table that gives the PIRQ each device interrupt pin (INTA to INTD) is wired to. A lookup port reads that table. Software reaches the routing bytes, the control byte and the table through one byte-wide register port.

Top module: `pirq_router`

## Requirements
- R1: After reset all 24 outputs are 0, every routing byte reads 0x80, the SCI control byte reads 0x00, and the SCI is placed on line 9.
- R2: The routing bytes of PIRQ A-D sit at addresses 0x00-0x03 and those of PIRQ E-H at 0x08-0x0B; each reads back the full byte last written, and a write to any address outside the decoded set changes nothing and that address reads 0.
- R3: PIC line L (0-15) is high when any PIRQ is high whose routing byte has bit 7 clear and bits [3:0] equal to L; a PIRQ whose bit 7 is set drives no PIC line.
- R4: APIC line 16+n follows the level of PIRQ n (A=0 ... H=7), whatever its routing byte holds.
- R5: The SCI control byte sits at 0x10; its bits [2:0] select the SCI line as 0→9, 1→10, 2→11, 4→20, 5→21, and the SCI level is ORed onto the selected line.
- R6: Writing a select code of 3, 6 or 7 keeps the previously selected SCI line; the byte still reads back as written.
- R7: When the SCI is high and the selected line changes, the old line falls and the new line rises in the same cycle.
- R8: Outputs are registered: an input level present at a rising edge shows after that edge, and a register write taken at a rising edge shows on the outputs after the next edge.
- R9: Slot s owns a 16-bit map word at byte addresses 0x40+2s (low byte) and 0x41+2s (high byte); pin p (INTA=0 ... INTD=3) uses bits [4p+3:4p], and the lookup returns the low three bits of that field. After reset the field holds ((s+p) mod 4)+4.
- R10: Slot 30's map word reads as zero and ignores writes, and its lookup always returns 4+p for pin p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Byte write strobe |
| reg_addr | input | 8 | Register byte address, for writes and reads |
| reg_wr_data | input | 8 | Write data |
| reg_rd_data | output | 8 | Read data for reg_addr, combinational |
| pirq_lvl | input | 8 | PIRQ A..H levels, bit 0 = A |
| sci_lvl | input | 1 | SCI request level |
| irq_line | output | 24 | Interrupt controller input levels |
| map_slot | input | 5 | Slot number for the pin lookup |
| map_pin | input | 2 | Interrupt pin for the lookup, 0 = INTA |
| map_pirq | output | 3 | PIRQ number for that slot and pin |

## Verification
The assertions assume that pirq_lvl and sci_lvl stay low while reset is held and for the cycle in which it is released. They also assume that every input changes only between clock edges. The bench keeps all levels at zero until a few cycles after reset and drives every input on the falling edge. With that in place, the checks that compare the outputs with the levels of one cycle earlier hold from the first armed cycle onward. Register writes appear only as single-cycle strobes, so the checks that require the routing and SCI state to stay stable see no spurious write.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;

  localparam int PIRQ_N   = 8;
  localparam int PIC_N    = 16;
  localparam int LINE_N   = 24;
  localparam int SLOT_N   = 32;
  localparam int PIN_N    = 4;
  localparam int FIELD_W  = 4;
  localparam int LINE_W   = 5;
  localparam int FIXED_SLOT = 30;

  localparam logic [7:0] ROUTE_LO_BASE = 8'h00;
  localparam logic [7:0] ROUTE_HI_BASE = 8'h08;
  localparam logic [7:0] SCI_CTRL_ADDR = 8'h10;
  localparam logic [7:0] SLOT_BASE     = 8'h40;

  localparam logic [7:0] ROUTE_RESET   = 8'h80;
  // bit 7 disable plus the line number field; bits [6:4] do not steer
  localparam logic [7:0] ROUTE_KEEP    = 8'h8F;
  localparam logic [2:0] SCI_RESET_CODE = 3'd0;
  localparam logic [LINE_W-1:0] SCI_RESET_LINE = 5'd9;

  function automatic logic sci_code_ok(input logic [2:0] code);
    return (code == 3'd0) || (code == 3'd1) || (code == 3'd2) ||
           (code == 3'd4) || (code == 3'd5);
  endfunction

  function automatic logic [LINE_W-1:0] sci_code_line(input logic [2:0] code);
    logic [LINE_W-1:0] ln;
    case (code)
      3'd1:    ln = 5'd10;
      3'd2:    ln = 5'd11;
      3'd4:    ln = 5'd20;
      3'd5:    ln = 5'd21;
      default: ln = 5'd9;
    endcase
    return ln;
  endfunction

endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_router_pkg::*;
#(
  parameter int NUM = PIRQ_N
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [7:0]           addr,
  input  logic [7:0]           wr_data,
  output logic [NUM-1:0][7:0]  route_q,
  output logic [7:0]           rd_data
);

  localparam int HALF = NUM / 2;

  logic [NUM-1:0][7:0] route_d;
  logic [NUM-1:0]      hit;

  for (genvar i = 0; i < NUM; i++) begin : g_route
    localparam logic [7:0] MY_ADDR = (i < HALF) ? 8'(ROUTE_LO_BASE + i)
                                                : 8'(ROUTE_HI_BASE + (i - HALF));
    assign hit[i] = (addr == MY_ADDR);

    always_comb begin
      route_d[i] = route_q[i];
      if (wr_en && hit[i]) route_d[i] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) route_q[i] <= ROUTE_RESET;
      else        route_q[i] <= route_d[i];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM; i++) begin
      if (hit[i]) rd_data = route_q[i];
    end
  end

  assert_route_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(route_q));

endmodule

// File: rtl/pirq_sci_select.sv
module pirq_sci_select
  import pirq_router_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        addr,
  input  logic [7:0]        wr_data,
  output logic [LINE_W-1:0] sci_line_q,
  output logic [7:0]        rd_data
);

  logic [7:0]        ctrl_q, ctrl_d;
  logic [LINE_W-1:0] sci_line_d;
  logic              hit, ctrl_we;

  assign hit     = (addr == SCI_CTRL_ADDR);
  assign ctrl_we = wr_en && hit;

  always_comb begin
    ctrl_d     = ctrl_q;
    sci_line_d = sci_line_q;
    if (ctrl_we) begin
      ctrl_d = wr_data;
      if (sci_code_ok(wr_data[2:0])) sci_line_d = sci_code_line(wr_data[2:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= {5'b0, SCI_RESET_CODE};
      sci_line_q <= SCI_RESET_LINE;
    end else begin
      ctrl_q     <= ctrl_d;
      sci_line_q <= sci_line_d;
    end
  end

  assign rd_data = hit ? ctrl_q : 8'h00;

  assert_reserved_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == SCI_CTRL_ADDR &&
     (wr_data[2:0] == 3'd3 || wr_data[2:0] >= 3'd6)) |=> $stable(sci_line_q));

  assert_line_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sci_line_q == 5'd9 || sci_line_q == 5'd10 || sci_line_q == 5'd11 ||
     sci_line_q == 5'd20 || sci_line_q == 5'd21));

endmodule

// File: rtl/pirq_slot_map.sv
module pirq_slot_map
  import pirq_router_pkg::*;
#(
  parameter int SLOTS = SLOT_N,
  parameter int PINS  = PIN_N,
  parameter int FIXED = FIXED_SLOT
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [7:0]                addr,
  input  logic [7:0]                wr_data,
  output logic [7:0]                rd_data,
  input  logic [$clog2(SLOTS)-1:0]  map_slot,
  input  logic [$clog2(PINS)-1:0]   map_pin,
  output logic [2:0]                map_pirq
);

  localparam int WORD_W = PINS * FIELD_W;
  localparam int BYTES  = WORD_W / 8;

  function automatic logic [WORD_W-1:0] default_word(input int s);
    logic [WORD_W-1:0] w;
    for (int p = 0; p < PINS; p++) w[p*FIELD_W +: FIELD_W] = FIELD_W'(((s + p) % 4) + 4);
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] fixed_word();
    logic [WORD_W-1:0] w;
    for (int p = 0; p < PINS; p++) w[p*FIELD_W +: FIELD_W] = FIELD_W'(4 + p);
    return w;
  endfunction

  logic [SLOTS-1:0][WORD_W-1:0] look_word;
  logic [SLOTS-1:0][WORD_W-1:0] read_word;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (s == FIXED) begin : g_fixed
      assign look_word[s] = fixed_word();
      assign read_word[s] = '0;
    end else begin : g_store
      logic [WORD_W-1:0] word_q, word_d;
      logic [BYTES-1:0]  byte_we;

      for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign byte_we[b] = wr_en && (addr == 8'(SLOT_BASE + BYTES*s + b));
      end

      always_comb begin
        word_d = word_q;
        for (int b = 0; b < BYTES; b++) begin
          if (byte_we[b]) word_d[b*8 +: 8] = wr_data;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= default_word(s);
        else        word_q <= word_d;
      end

      assign look_word[s] = word_q;
      assign read_word[s] = word_q;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int s = 0; s < SLOTS; s++) begin
      for (int b = 0; b < BYTES; b++) begin
        if (addr == 8'(SLOT_BASE + BYTES*s + b)) rd_data = read_word[s][b*8 +: 8];
      end
    end
  end

  logic [FIELD_W-1:0] field;
  assign field    = look_word[map_slot][map_pin*FIELD_W +: FIELD_W];
  assign map_pirq = 3'(field);

  assert_fixed_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 8'(SLOT_BASE + BYTES*FIXED) || addr == 8'(SLOT_BASE + BYTES*FIXED + 1))
      |-> rd_data == 8'h00);

  assert_fixed_lookup_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(map_slot) == FIXED) |-> (map_pirq == 3'(4 + 32'(map_pin))));

endmodule

// File: rtl/pirq_line_merge.sv
module pirq_line_merge
  import pirq_router_pkg::*;
#(
  parameter int NUM_PIRQ = PIRQ_N,
  parameter int NUM_PIC  = PIC_N,
  parameter int NUM_LINE = LINE_N
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_PIRQ-1:0][7:0]  route_q,
  input  logic [NUM_PIRQ-1:0]       pirq_lvl,
  input  logic                      sci_lvl,
  input  logic [LINE_W-1:0]         sci_line,
  output logic [NUM_LINE-1:0]       lines_q
);

  logic [NUM_LINE-1:0] lines_d;
  logic [NUM_LINE-1:0] sci_vec;

  for (genvar l = 0; l < NUM_LINE; l++) begin : g_line
    assign sci_vec[l] = sci_lvl && (sci_line == LINE_W'(l));

    if (l < NUM_PIC) begin : g_pic
      logic [NUM_PIRQ-1:0] hit;
      for (genvar i = 0; i < NUM_PIRQ; i++) begin : g_src
        assign hit[i] = pirq_lvl[i] && ((route_q[i] & ROUTE_KEEP) == 8'(l));
      end
      assign lines_d[l] = (|hit) || sci_vec[l];
    end else begin : g_apic
      assign lines_d[l] = pirq_lvl[l - NUM_PIC] || sci_vec[l];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lines_q <= '0;
    else        lines_q <= lines_d;
  end

  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assert_apic_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !$past(sci_lvl)) |-> lines_q[NUM_LINE-1:NUM_PIC] == $past(pirq_lvl));

  assert_quiet_inputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(pirq_lvl) == '0 && !$past(sci_lvl)) |-> lines_q == '0);

  assert_sci_shows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(sci_lvl)) |-> lines_q != '0);

endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_router_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [7:0]  reg_addr,
  input  logic [7:0]  reg_wr_data,
  output logic [7:0]  reg_rd_data,
  input  logic [7:0]  pirq_lvl,
  input  logic        sci_lvl,
  output logic [23:0] irq_line,
  input  logic [4:0]  map_slot,
  input  logic [1:0]  map_pin,
  output logic [2:0]  map_pirq
);

  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [PIRQ_N-1:0][7:0] route_q;
  logic [LINE_W-1:0]      sci_line;
  logic [7:0]             rd_route, rd_sci, rd_map;

  pirq_route_regs #(.NUM(PIRQ_N)) u_route (
    .clk(clk), .rst_n(rst_sync_q), .wr_en(reg_wr_en), .addr(reg_addr),
    .wr_data(reg_wr_data), .route_q(route_q), .rd_data(rd_route)
  );

  pirq_sci_select u_sci (
    .clk(clk), .rst_n(rst_sync_q), .wr_en(reg_wr_en), .addr(reg_addr),
    .wr_data(reg_wr_data), .sci_line_q(sci_line), .rd_data(rd_sci)
  );

  pirq_slot_map #(.SLOTS(SLOT_N), .PINS(PIN_N), .FIXED(FIXED_SLOT)) u_map (
    .clk(clk), .rst_n(rst_sync_q), .wr_en(reg_wr_en), .addr(reg_addr),
    .wr_data(reg_wr_data), .rd_data(rd_map), .map_slot(map_slot),
    .map_pin(map_pin), .map_pirq(map_pirq)
  );

  pirq_line_merge #(.NUM_PIRQ(PIRQ_N), .NUM_PIC(PIC_N), .NUM_LINE(LINE_N)) u_merge (
    .clk(clk), .rst_n(rst_sync_q), .route_q(route_q), .pirq_lvl(pirq_lvl),
    .sci_lvl(sci_lvl), .sci_line(sci_line), .lines_q(irq_line)
  );

  // decoded windows do not overlap, so a plain OR selects the one hit
  assign reg_rd_data = rd_route | rd_sci | rd_map;

endmodule

// File: tb/pirq_router_tb.sv
module pirq_router_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [7:0]  reg_addr, reg_wr_data, reg_rd_data;
  logic [7:0]  pirq_lvl;
  logic        sci_lvl;
  logic [23:0] irq_line;
  logic [4:0]  map_slot;
  logic [1:0]  map_pin;
  logic [2:0]  map_pirq;

  always #5 clk = ~clk;

  pirq_router u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data), .pirq_lvl(pirq_lvl),
    .sci_lvl(sci_lvl), .irq_line(irq_line), .map_slot(map_slot),
    .map_pin(map_pin), .map_pirq(map_pirq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  logic [7:0]  m_route [8];
  logic [7:0]  m_ctrl;
  int          m_sci_line;
  logic [15:0] m_map [32];
  logic [23:0] m_exp;

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_route[i] = 8'h80;
    m_ctrl = 8'h00;
    m_sci_line = 9;
    for (int s = 0; s < 32; s++)
      for (int p = 0; p < 4; p++) m_map[s][4*p +: 4] = 4'(((s + p) % 4) + 4);
    m_exp = '0;
  endtask

  function automatic logic [23:0] model_lines();
    logic [23:0] r;
    for (int ln = 0; ln < 24; ln++) begin
      bit v = 0;
      if (ln < 16) begin
        for (int i = 0; i < 8; i++)
          if (pirq_lvl[i] && !m_route[i][7] && int'(m_route[i][3:0]) == ln) v = 1;
      end else begin
        v = pirq_lvl[ln - 16];
      end
      if (sci_lvl && m_sci_line == ln) v = 1;
      r[ln] = v;
    end
    return r;
  endfunction

  function automatic int route_idx(input logic [7:0] a);
    if (a <= 8'h03) return int'(a);
    if (a >= 8'h08 && a <= 8'h0B) return int'(a) - 4;
    return -1;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    int ri, s;
    ri = route_idx(a);
    if (ri >= 0) m_route[ri] = d;
    if (a == 8'h10) begin
      m_ctrl = d;
      case (d[2:0])
        3'd0: m_sci_line = 9;
        3'd1: m_sci_line = 10;
        3'd2: m_sci_line = 11;
        3'd4: m_sci_line = 20;
        3'd5: m_sci_line = 21;
        default: ;
      endcase
    end
    if (a >= 8'h40 && a < 8'h80) begin
      s = (int'(a) - 64) / 2;
      if (s != 30) m_map[s][8*(int'(a) % 2) +: 8] = d;
    end
  endtask

  function automatic logic [7:0] model_read(input logic [7:0] a);
    int ri, s;
    ri = route_idx(a);
    if (ri >= 0) return m_route[ri];
    if (a == 8'h10) return m_ctrl;
    if (a >= 8'h40 && a < 8'h80) begin
      s = (int'(a) - 64) / 2;
      if (s == 30) return 8'h00;
      return m_map[s][8*(int'(a) % 2) +: 8];
    end
    return 8'h00;
  endfunction

  function automatic logic [2:0] model_lookup(input int s, input int p);
    if (s == 30) return 3'(4 + p);
    return m_map[s][4*p +: 3];
  endfunction

  // the model mirrors the synchronised reset: two edges of delay
  int rst_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_cnt = 0;
      model_reset();
    end else if (rst_cnt < 2) begin
      rst_cnt++;
      model_reset();
    end else begin
      m_exp = model_lines();
      if (reg_wr_en) model_write(reg_addr, reg_wr_data);
    end
  end

  // per-cycle comparison against the model, R8 timing included
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq_line !== m_exp) begin
        errors++;
        for (int ln = 0; ln < 24; ln++)
          if (irq_line[ln] !== m_exp[ln])
            $display("FAIL %s line %0d actual %b expected %b",
                     (ln < 16) ? "R3/R5/R8" : "R4/R5/R8", ln, irq_line[ln], m_exp[ln]);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
    reg_addr = a; #1;
    chk(req, 32'(reg_rd_data), 32'(exp));
  endtask

  task automatic look(input int s, input int p, input int exp, input string req);
    map_slot = 5'(s); map_pin = 2'(p); #1;
    chk(req, 32'(map_pirq), 32'(exp));
  endtask

  task automatic set_in(input logic [7:0] pv, input logic sv);
    @(negedge clk);
    pirq_lvl = pv; sci_lvl = sv;
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wr_data = '0;
    pirq_lvl = '0; sci_lvl = 1'b0; map_slot = '0; map_pin = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); #3 rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    chk("R1 outputs", 32'(irq_line), 0);
    for (int a = 0; a < 4; a++) rd(8'(a), 8'h80, "R1 route A-D");
    for (int a = 8; a < 12; a++) rd(8'(a), 8'h80, "R1 route E-H");
    rd(8'h10, 8'h00, "R1 sci ctrl");

    // R9 default map and lookups
    rd(8'h40, 8'h54, "R9 slot0 low");
    rd(8'h41, 8'h76, "R9 slot0 high");
    rd(8'h42, 8'h65, "R9 slot1 low");
    rd(8'h43, 8'h47, "R9 slot1 high");
    look(2, 1, 7, "R9 default slot2 pinB");
    look(31, 3, 6, "R9 default slot31 pinD");

    // R10 fixed slot
    rd(8'h7C, 8'h00, "R10 read low");
    rd(8'h7D, 8'h00, "R10 read high");
    wr(8'h7C, 8'hFF);
    wr(8'h7D, 8'hFF);
    rd(8'h7C, 8'h00, "R10 after write low");
    rd(8'h7D, 8'h00, "R10 after write high");
    look(30, 0, 4, "R10 pinA");
    look(30, 3, 7, "R10 pinD");

    // R9 write little-endian map word
    wr(8'h42, 8'h21);
    wr(8'h43, 8'h03);
    look(1, 0, 1, "R9 slot1 pinA");
    look(1, 1, 2, "R9 slot1 pinB");
    look(1, 2, 3, "R9 slot1 pinC");
    look(1, 3, 0, "R9 slot1 pinD");
    wr(8'h44, 8'h0F);
    look(2, 0, 7, "R9 field low three bits");

    // R4 and R3 with all PIRQs disabled on the PIC side
    set_in(8'b1010_0001, 1'b0);
    step();
    chk("R4 apic lines", 32'(irq_line[23:16]), 32'h0A1);
    chk("R3 disabled pic quiet", 32'(irq_line[15:0]), 0);

    // R3 routing to a shared PIC line, R8 write latency
    set_in(8'h01, 1'b0);
    wr(8'h00, 8'h05);
    chk("R8 write not yet visible", 32'(irq_line[5]), 0);
    step();
    chk("R3 A on line5", 32'(irq_line[5]), 1);
    wr(8'h01, 8'h05);
    set_in(8'h02, 1'b0);
    step();
    chk("R3 B on shared line5", 32'(irq_line[5]), 1);
    set_in(8'h00, 1'b0);
    step();
    chk("R3 line5 low", 32'(irq_line[5]), 0);
    wr(8'h01, 8'h85);
    set_in(8'h02, 1'b0);
    step();
    chk("R3 B disabled", 32'(irq_line[5]), 0);
    chk("R4 B on apic", 32'(irq_line[17]), 1);

    // R2 second block and undecoded addresses
    wr(8'h0B, 8'h7C);
    rd(8'h0B, 8'h7C, "R2 readback H");
    set_in(8'h80, 1'b0);
    step();
    chk("R2 H on line12", 32'(irq_line[12]), 1);
    chk("R4 H on apic", 32'(irq_line[23]), 1);
    wr(8'h04, 8'h03);
    rd(8'h04, 8'h00, "R2 gap reads zero");
    rd(8'h03, 8'h80, "R2 gap write no effect");
    set_in(8'h00, 1'b0);

    // R5 SCI merge, R7 move, R6 reserved
    set_in(8'h00, 1'b1);
    step();
    chk("R5 sci on line9", 32'(irq_line), 32'h200);
    wr(8'h10, 8'h04);
    step();
    chk("R7 sci moved to 20", 32'(irq_line), 32'h10_0000);
    rd(8'h10, 8'h04, "R5 ctrl readback");
    wr(8'h10, 8'h03);
    step();
    chk("R6 reserved keeps 20", 32'(irq_line), 32'h10_0000);
    rd(8'h10, 8'h03, "R6 byte reads as written");
    wr(8'h10, 8'h07);
    step();
    chk("R6 code 7 keeps 20", 32'(irq_line), 32'h10_0000);
    wr(8'h10, 8'h05);
    step();
    chk("R5 code5 line21", 32'(irq_line), 32'h20_0000);
    wr(8'h10, 8'h02);
    step();
    chk("R5 code2 line11", 32'(irq_line), 32'h800);
    set_in(8'h00, 1'b0);
    step();
    chk("R5 sci low", 32'(irq_line), 0);

    // mixed stimulus, compared to the model every cycle
    for (int it = 0; it < 400; it++) begin
      int pick;
      logic [7:0] a;
      pick = $urandom_range(0, 8);
      a = (pick < 4) ? 8'(pick) : (pick < 8) ? 8'(pick + 4) : 8'h10;
      if ($urandom_range(0, 2) == 0) wr(a, 8'($urandom));
      set_in(8'($urandom), 1'($urandom_range(0, 3) == 0));
      if (it % 8 == 0) begin
        #1;
        rd(a, model_read(a), "R2/R5 readback");
        look(it % 32, it % 4, int'(model_lookup(it % 32, it % 4)), "R9 lookup");
      end
    end
    set_in(8'h00, 1'b0);
    repeat (3) step();
    finish_run();
  end

endmodule